// File: doc/BRIEF.md
# Picture-in-picture window compositor

This block sits on the main-picture pixel path. It keeps its own horizontal and vertical position by counting main-picture pixel clocks from the rising edge of the horizontal sync input, and lines from the active-high vertical sync input. When the overlay is active, it fetches the stored sub-picture through a synchronous read port. Each 6-bit stored sample is widened back to 8 bits. Inside a rectangular window, the sub-picture replaces the main picture's luma and its two colour-difference components.

The window sits in one of four screen corners, with a fixed margin from the edges. Its height follows the stored size (large or small) and its width is the stored line width. A thin border can frame the window. The border's luma comes from a control input and its chroma is neutral. The overlay appears only while both the enable control and the external display-enable pin are high. Otherwise the main picture passes through unchanged, with the same latency.

Top module: `pip_compositor`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `out_y`, `out_u` and `out_v` are 0 and `rd_en` is low.
- R2: In any pixel where `pip_en` or `disp_en` is low, the output equals the main-picture input of that pixel, and no read is issued for it (`rd_en` low in the following cycle).
- R3: Window placement uses `corner`. Bit 0 set places it at the right edge, and clear at the left. Bit 1 set places it at the bottom, and clear at the top. The picture starts MARGIN_H pixels from the left edge, or ends MARGIN_H pixels before the line end. It starts MARGIN_V lines below the top, or ends MARGIN_V lines before the field end.
- R4: The window is SUB_W pixels wide. It is LINES_L lines tall when `size_sel` is 0 and LINES_S lines tall when `size_sel` is 1. Exactly that many reads are issued per field while the overlay is active.
- R5: A 6-bit stored sample d is shown as the 8-bit value {d, d[5:4]}. Luma comes from `rd_y` and chroma from `rd_u` and `rd_v`.
- R6: For the picture pixel at row r and column c, the luma address is r*SUB_W + c and the chroma address is r*ceil(SUB_W/CHROMA_HOLD) + c/CHROMA_HOLD. Within a row, the luma address rises by 1 each pixel, and the chroma address rises at most by 1 each pixel.
- R7: With `border_en` high, a frame BORDER_W pixels wide at the sides and BORDER_H lines tall at the top and bottom surrounds the picture, outside it. The frame shows `border_lvl` as luma and 128 on both chroma outputs. With `border_en` low, that frame shows the main picture.
- R8: The pixel position is 0 in the cycle after `hsync` is first seen high. The line number advances at each `hsync` rising edge. The line number is 0 when a `vsync` rising edge occurs.
- R9: The output for a pixel appears three clock cycles after its main-picture input. The read port returns data one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main-picture pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| vsync | input | 1 | Vertical sync, active high |
| disp_en | input | 1 | External display enable, active high |
| pip_en | input | 1 | Overlay enable control |
| size_sel | input | 1 | 0 = large window, 1 = small window |
| corner | input | 2 | Window corner, bit 0 right, bit 1 bottom |
| border_en | input | 1 | Border frame on |
| border_lvl | input | 8 | Border luma level |
| main_y | input | 8 | Main-picture luma |
| main_u | input | 8 | Main-picture blue colour difference |
| main_v | input | 8 | Main-picture red colour difference |
| rd_en | output | 1 | Sub-picture read request |
| rd_y_addr | output | YAW | Luma read address |
| rd_c_addr | output | CAW | Chroma read address |
| rd_y | input | 6 | Stored luma, one cycle after request |
| rd_u | input | 6 | Stored blue colour difference |
| rd_v | input | 6 | Stored red colour difference |
| out_y | output | 8 | Composited luma |
| out_u | output | 8 | Composited blue colour difference |
| out_v | output | 8 | Composited red colour difference |

## Verification
Each field is driven with a main picture that changes every pixel, and a memory model whose data is a distinct function of address. A wrong position, a wrong latency or a wrong address each shows up as a mismatch, and the mismatches are sorted into picture, border and main classes.

The cases cover:
- all four corners and both sizes, so a swapped corner bit or size is caught;
- the border on and off, and two border levels;
- the overlay disabled by control and by the pin;
- a display-enable pin that toggles every four pixels, which separates per-pixel gating from gating latched once per line.

// File: rtl/pip_pkg.sv
package pip_pkg;
  localparam int SAMPLE_W = 6;
  localparam int PIX_W    = 8;

  typedef struct packed {
    logic [PIX_W-1:0] y;
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] v;
  } pix_t;

  typedef enum logic [1:0] {
    SRC_MAIN   = 2'd0,
    SRC_PIC    = 2'd1,
    SRC_BORDER = 2'd2
  } src_e;

  // Widen a stored sample by repeating its top bits in the freed low bits.
  function automatic logic [PIX_W-1:0] widen(input logic [SAMPLE_W-1:0] d);
    return {d, d[SAMPLE_W-1 -: (PIX_W-SAMPLE_W)]};
  endfunction
endpackage

// File: rtl/pip_timing.sv
module pip_timing #(
  parameter int H_TOTAL = 910,
  parameter int V_TOTAL = 262,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsync,
  input  logic          vsync,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          h_start,
  output logic          v_start
);
  logic hs_q, vs_q;

  assign h_start = hsync & ~hs_q;
  assign v_start = vsync & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      hpos <= '0;
      vpos <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (h_start)
        hpos <= '0;
      else if (hpos == HW'(H_TOTAL-1))
        hpos <= '0;
      else
        hpos <= hpos + HW'(1);
      if (v_start)
        vpos <= '0;
      else if (h_start)
        vpos <= (vpos == VW'(V_TOTAL-1)) ? '0 : vpos + VW'(1);
    end
  end
endmodule

// File: rtl/pip_window.sv
module pip_window #(
  parameter int H_TOTAL     = 910,
  parameter int V_TOTAL     = 262,
  parameter int SUB_W       = 171,
  parameter int LINES_L     = 69,
  parameter int LINES_S     = 52,
  parameter int MARGIN_H    = 16,
  parameter int MARGIN_V    = 12,
  parameter int BORDER_W    = 2,
  parameter int BORDER_H    = 1,
  parameter int CHROMA_HOLD = 6,
  parameter int YAW         = 14,
  parameter int CAW         = 11,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int CW = (SUB_W + CHROMA_HOLD - 1) / CHROMA_HOLD
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HW-1:0]  hpos,
  input  logic [VW-1:0]  vpos,
  input  logic           h_start,
  input  logic           v_start,
  input  logic [1:0]     corner,
  input  logic           size_sel,
  input  logic           border_en,
  input  logic           act,
  output logic           in_pic,
  output logic           in_brd,
  output logic [YAW-1:0] y_addr,
  output logic [CAW-1:0] c_addr
);
  localparam logic [HW-1:0] X_LEFT  = HW'(MARGIN_H);
  localparam logic [HW-1:0] X_RIGHT = HW'(H_TOTAL - MARGIN_H - SUB_W);
  localparam logic [HW-1:0] PIC_W   = HW'(SUB_W);
  localparam logic [HW-1:0] BRD_W   = HW'(BORDER_W);
  localparam logic [VW-1:0] Y_TOP   = VW'(MARGIN_V);
  localparam logic [VW-1:0] Y_BOT_L = VW'(V_TOTAL - MARGIN_V - LINES_L);
  localparam logic [VW-1:0] Y_BOT_S = VW'(V_TOTAL - MARGIN_V - LINES_S);
  localparam logic [VW-1:0] NL_L    = VW'(LINES_L);
  localparam logic [VW-1:0] NL_S    = VW'(LINES_S);
  localparam logic [VW-1:0] BRD_H   = VW'(BORDER_H);

  logic [HW-1:0] x0;
  logic [VW-1:0] y0, nlines;
  logic x_in, y_in, x_brd, y_brd;

  assign x0     = corner[0] ? X_RIGHT : X_LEFT;
  assign nlines = size_sel ? NL_S : NL_L;
  assign y0     = corner[1] ? (size_sel ? Y_BOT_S : Y_BOT_L) : Y_TOP;

  assign x_in  = (hpos >= x0) && (hpos < x0 + PIC_W);
  assign y_in  = (vpos >= y0) && (vpos < y0 + nlines);
  assign x_brd = (hpos >= x0 - BRD_W) && (hpos < x0 + PIC_W + BRD_W);
  assign y_brd = (vpos >= y0 - BRD_H) && (vpos < y0 + nlines + BRD_H);

  assign in_pic = act && x_in && y_in;
  assign in_brd = act && border_en && x_brd && y_brd && !(x_in && y_in);

  // Address bookkeeping: per-line column counters, per-field row bases.
  logic [YAW-1:0] col, ybase;
  logic [CAW-1:0] ccol, cbase;

  always_ff @(posedge clk) begin
    if (rst || h_start)
      col <= '0;
    else if (x_in)
      col <= col + YAW'(1);
  end

  generate
    if (CHROMA_HOLD > 1) begin : g_hold
      localparam int PW = $clog2(CHROMA_HOLD);
      logic [PW-1:0] ph;
      always_ff @(posedge clk) begin
        if (rst || h_start) begin
          ph   <= '0;
          ccol <= '0;
        end else if (x_in) begin
          if (ph == PW'(CHROMA_HOLD-1)) begin
            ph   <= '0;
            ccol <= ccol + CAW'(1);
          end else begin
            ph <= ph + PW'(1);
          end
        end
      end
    end else begin : g_nohold
      always_ff @(posedge clk) begin
        if (rst || h_start)
          ccol <= '0;
        else if (x_in)
          ccol <= ccol + CAW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || v_start) begin
      ybase <= '0;
      cbase <= '0;
    end else if (h_start && y_in) begin
      ybase <= ybase + YAW'(SUB_W);
      cbase <= cbase + CAW'(CW);
    end
  end

  assign y_addr = ybase + col;
  assign c_addr = cbase + ccol;
endmodule

// File: rtl/pip_mixer.sv
module pip_mixer
  import pip_pkg::*;
#(
  parameter int YAW = 14,
  parameter int CAW = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_pic,
  input  logic                in_brd,
  input  logic [YAW-1:0]      y_addr,
  input  logic [CAW-1:0]      c_addr,
  input  pix_t                main_px,
  input  logic [PIX_W-1:0]    border_lvl,
  input  logic [SAMPLE_W-1:0] rd_y,
  input  logic [SAMPLE_W-1:0] rd_u,
  input  logic [SAMPLE_W-1:0] rd_v,
  output logic                rd_en,
  output logic [YAW-1:0]      rd_y_addr,
  output logic [CAW-1:0]      rd_c_addr,
  output pix_t                out_px
);
  localparam logic [PIX_W-1:0] NEUTRAL = PIX_W'(1 << (PIX_W-1));

  src_e             src1, src2;
  pix_t             main1, main2;
  logic [PIX_W-1:0] lvl1, lvl2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      rd_y_addr <= '0;
      rd_c_addr <= '0;
      src1      <= SRC_MAIN;
      main1     <= '0;
      lvl1      <= '0;
      src2      <= SRC_MAIN;
      main2     <= '0;
      lvl2      <= '0;
      out_px    <= '0;
    end else begin
      rd_en     <= in_pic;
      rd_y_addr <= y_addr;
      rd_c_addr <= c_addr;
      src1      <= in_pic ? SRC_PIC : (in_brd ? SRC_BORDER : SRC_MAIN);
      main1     <= main_px;
      lvl1      <= border_lvl;
      src2      <= src1;
      main2     <= main1;
      lvl2      <= lvl1;
      unique case (src2)
        SRC_PIC:    out_px <= '{y: widen(rd_y), u: widen(rd_u), v: widen(rd_v)};
        SRC_BORDER: out_px <= '{y: lvl2, u: NEUTRAL, v: NEUTRAL};
        default:    out_px <= main2;
      endcase
    end
  end
endmodule

// File: rtl/pip_compositor.sv
module pip_compositor
  import pip_pkg::*;
#(
  parameter int H_TOTAL     = 910,
  parameter int V_TOTAL     = 262,
  parameter int SUB_W       = 171,
  parameter int LINES_L     = 69,
  parameter int LINES_S     = 52,
  parameter int MARGIN_H    = 16,
  parameter int MARGIN_V    = 12,
  parameter int BORDER_W    = 2,
  parameter int BORDER_H    = 1,
  parameter int CHROMA_HOLD = 6,
  localparam int LMAX = (LINES_L > LINES_S) ? LINES_L : LINES_S,
  localparam int CW   = (SUB_W + CHROMA_HOLD - 1) / CHROMA_HOLD,
  localparam int YAW  = $clog2(SUB_W * LMAX),
  localparam int CAW  = $clog2(CW * LMAX)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hsync,
  input  logic                vsync,
  input  logic                disp_en,
  input  logic                pip_en,
  input  logic                size_sel,
  input  logic [1:0]          corner,
  input  logic                border_en,
  input  logic [PIX_W-1:0]    border_lvl,
  input  logic [PIX_W-1:0]    main_y,
  input  logic [PIX_W-1:0]    main_u,
  input  logic [PIX_W-1:0]    main_v,
  output logic                rd_en,
  output logic [YAW-1:0]      rd_y_addr,
  output logic [CAW-1:0]      rd_c_addr,
  input  logic [SAMPLE_W-1:0] rd_y,
  input  logic [SAMPLE_W-1:0] rd_u,
  input  logic [SAMPLE_W-1:0] rd_v,
  output logic [PIX_W-1:0]    out_y,
  output logic [PIX_W-1:0]    out_u,
  output logic [PIX_W-1:0]    out_v
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0]  hpos;
  logic [VW-1:0]  vpos;
  logic           h_start, v_start;
  logic           in_pic, in_brd;
  logic [YAW-1:0] y_addr;
  logic [CAW-1:0] c_addr;
  pix_t           main_px, out_px;

  assign main_px = '{y: main_y, u: main_u, v: main_v};
  assign out_y   = out_px.y;
  assign out_u   = out_px.u;
  assign out_v   = out_px.v;

  pip_timing #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_timing (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .hpos(hpos), .vpos(vpos), .h_start(h_start), .v_start(v_start)
  );

  pip_window #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .SUB_W(SUB_W),
    .LINES_L(LINES_L), .LINES_S(LINES_S),
    .MARGIN_H(MARGIN_H), .MARGIN_V(MARGIN_V),
    .BORDER_W(BORDER_W), .BORDER_H(BORDER_H),
    .CHROMA_HOLD(CHROMA_HOLD), .YAW(YAW), .CAW(CAW)
  ) u_window (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos),
    .h_start(h_start), .v_start(v_start),
    .corner(corner), .size_sel(size_sel), .border_en(border_en),
    .act(pip_en & disp_en),
    .in_pic(in_pic), .in_brd(in_brd), .y_addr(y_addr), .c_addr(c_addr)
  );

  pip_mixer #(.YAW(YAW), .CAW(CAW)) u_mixer (
    .clk(clk), .rst(rst), .in_pic(in_pic), .in_brd(in_brd),
    .y_addr(y_addr), .c_addr(c_addr), .main_px(main_px),
    .border_lvl(border_lvl), .rd_y(rd_y), .rd_u(rd_u), .rd_v(rd_v),
    .rd_en(rd_en), .rd_y_addr(rd_y_addr), .rd_c_addr(rd_c_addr),
    .out_px(out_px)
  );
endmodule

// File: rtl/pip_compositor_chk.sv
module pip_compositor_chk #(
  parameter int YAW = 14,
  parameter int CAW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           pip_en,
  input logic           disp_en,
  input logic [7:0]     main_y,
  input logic [7:0]     main_u,
  input logic [7:0]     main_v,
  input logic           rd_en,
  input logic [YAW-1:0] rd_y_addr,
  input logic [CAW-1:0] rd_c_addr,
  input logic [7:0]     out_y,
  input logic [7:0]     out_u,
  input logic [7:0]     out_v
);
  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_y == 8'd0 && out_u == 8'd0 && out_v == 8'd0 && !rd_en));

  // R2: no read for an inactive pixel
  a_r2_no_read_inactive: assert property (@(posedge clk) disable iff (rst)
    !(pip_en && disp_en) |=> !rd_en);

  // R2, R9: inactive pixel passes through three cycles later
  a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
     $past(!(pip_en && disp_en), 3))
    |-> (out_y == $past(main_y, 3) && out_u == $past(main_u, 3) &&
         out_v == $past(main_v, 3)));

  // R6: luma address steps by one between consecutive reads
  a_r6_luma_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_y_addr == $past(rd_y_addr) + YAW'(1)));

  // R6: chroma address holds or steps by one
  a_r6_chroma_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |->
      (rd_c_addr == $past(rd_c_addr) || rd_c_addr == $past(rd_c_addr) + CAW'(1)));
endmodule

bind pip_compositor pip_compositor_chk #(.YAW(YAW), .CAW(CAW)) u_chk (
  .clk(clk), .rst(rst), .pip_en(pip_en), .disp_en(disp_en),
  .main_y(main_y), .main_u(main_u), .main_v(main_v),
  .rd_en(rd_en), .rd_y_addr(rd_y_addr), .rd_c_addr(rd_c_addr),
  .out_y(out_y), .out_u(out_u), .out_v(out_v)
);

// File: tb/tb_pip_compositor.sv
`timescale 1ns/1ps
module tb_pip_compositor;
  localparam int HT = 64, VT = 40, SW = 14, LL = 8, LS = 5;
  localparam int MH = 4, MV = 3, BW = 2, BH = 1, CH = 6;
  localparam int CW  = (SW + CH - 1) / CH;
  localparam int YAW = $clog2(SW * LL);
  localparam int CAW = $clog2(CW * LL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync = 1'b0, vsync = 1'b0, disp_en = 1'b1, pip_en = 1'b0;
  logic size_sel = 1'b0, border_en = 1'b0;
  logic [1:0] corner = 2'd0;
  logic [7:0] border_lvl = 8'd0, main_y = 8'h5A, main_u = 8'hA5, main_v = 8'h3C;
  logic rd_en;
  logic [YAW-1:0] rd_y_addr;
  logic [CAW-1:0] rd_c_addr;
  logic [5:0] rd_y = 6'd0, rd_u = 6'd0, rd_v = 6'd0;
  logic [7:0] out_y, out_u, out_v;

  always #5 clk = ~clk;

  pip_compositor #(
    .H_TOTAL(HT), .V_TOTAL(VT), .SUB_W(SW), .LINES_L(LL), .LINES_S(LS),
    .MARGIN_H(MH), .MARGIN_V(MV), .BORDER_W(BW), .BORDER_H(BH), .CHROMA_HOLD(CH)
  ) dut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .pip_en(pip_en), .size_sel(size_sel), .corner(corner), .border_en(border_en),
    .border_lvl(border_lvl), .main_y(main_y), .main_u(main_u), .main_v(main_v),
    .rd_en(rd_en), .rd_y_addr(rd_y_addr), .rd_c_addr(rd_c_addr),
    .rd_y(rd_y), .rd_u(rd_u), .rd_v(rd_v),
    .out_y(out_y), .out_u(out_u), .out_v(out_v)
  );

  function automatic logic [5:0] fy(input int a); return 6'(a * 5 + 3); endfunction
  function automatic logic [5:0] fu(input int a); return 6'(a * 3 + 1); endfunction
  function automatic logic [5:0] fv(input int a); return 6'(a * 7 + 2); endfunction
  function automatic logic [7:0] w8(input logic [5:0] d); return {d, d[5:4]}; endfunction

  // Synchronous sub-picture memory model (R9: data one cycle after request)
  always @(posedge clk) begin
    if (rd_en) begin
      rd_y <= fy(int'(rd_y_addr));
      rd_u <= fu(int'(rd_c_addr));
      rd_v <= fv(int'(rd_c_addr));
    end
  end

  int tests = 0, fails = 0;
  task automatic check(input string what, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // Pending configuration, applied by the generator at a field start
  logic p_pip = 1'b0, p_size = 1'b0, p_ben = 1'b0;
  logic [1:0] p_corner = 2'd0;
  logic [7:0] p_lvl = 8'd0;
  int p_dmode = 0, dmode = 0;

  int frame_cnt = 0;
  int pic_err = 0, brd_err = 0, main_err = 0, rd_cnt = 0, pic_exp = 0, max_ya = 0;
  logic go = 1'b0;

  logic [7:0] qy[3], qu[3], qv[3];
  int qs[3];
  logic qok[3];

  initial begin
    int hc = 0, lc = 0, n = 0;
    logic primed = 1'b0;
    for (int i = 0; i < 3; i++) qok[i] = 1'b0;
    wait (go);
    forever begin
      @(negedge clk);
      // compare against the entry made three cycles earlier (R9)
      if (qok[2]) begin
        if (qs[2] == 1) pic_exp++;
        if (out_y !== qy[2] || out_u !== qu[2] || out_v !== qv[2]) begin
          if (qs[2] == 1) pic_err++;
          else if (qs[2] == 2) brd_err++;
          else main_err++;
        end
      end
      if (rd_en) begin
        rd_cnt++;
        if (int'(rd_y_addr) > max_ya) max_ya = int'(rd_y_addr);
      end
      for (int i = 2; i > 0; i--) begin
        qy[i] = qy[i-1]; qu[i] = qu[i-1]; qv[i] = qv[i-1];
        qs[i] = qs[i-1]; qok[i] = qok[i-1];
      end
      if (hc == 0 && lc == 0) begin
        pip_en = p_pip; size_sel = p_size; border_en = p_ben;
        corner = p_corner; border_lvl = p_lvl; dmode = p_dmode;
        frame_cnt++;
      end
      hsync = (hc == 0);
      vsync = (hc == 0 && lc == 0);
      disp_en = (dmode == 0) ? 1'b1 : (dmode == 1) ? 1'b0 : 1'(hc >> 2);
      main_y = 8'(n * 7 + 1);
      main_u = 8'(n * 3);
      main_v = 8'(255 - n);
      begin
        // R8: position seen by the block in this cycle
        int dh, dv, x0, y0, nl, src;
        logic act, pic, brd;
        dh = (hc == 0) ? HT - 1 : hc - 1;
        dv = (hc == 0) ? ((lc == 0) ? VT - 1 : lc - 1) : lc;
        nl = size_sel ? LS : LL;
        x0 = corner[0] ? HT - MH - SW : MH;
        y0 = corner[1] ? VT - MV - nl : MV;
        act = pip_en && disp_en;
        pic = act && dh >= x0 && dh < x0 + SW && dv >= y0 && dv < y0 + nl;
        brd = act && border_en && !pic && dh >= x0 - BW && dh < x0 + SW + BW &&
              dv >= y0 - BH && dv < y0 + nl + BH;
        if (pic) begin
          int ya, ca;
          ya = (dv - y0) * SW + (dh - x0);
          ca = (dv - y0) * CW + (dh - x0) / CH;
          qy[0] = w8(fy(ya)); qu[0] = w8(fu(ca)); qv[0] = w8(fv(ca));
          src = 1;
        end else if (brd) begin
          qy[0] = border_lvl; qu[0] = 8'd128; qv[0] = 8'd128;
          src = 2;
        end else begin
          qy[0] = main_y; qu[0] = main_u; qv[0] = main_v;
          src = 0;
        end
        qs[0] = src;
        qok[0] = primed;
      end
      if (hc == 0 && lc == 0) primed = 1'b1;
      n++;
      if (hc == HT - 1) begin
        hc = 0;
        lc = (lc == VT - 1) ? 0 : lc + 1;
      end else begin
        hc++;
      end
    end
  end

  task automatic run_field(input string tag, input logic pip, input logic size,
                           input logic [1:0] crn, input logic ben,
                           input logic [7:0] lvl, input int dm);
    int f, nl;
    p_pip = pip; p_size = size; p_corner = crn; p_ben = ben; p_lvl = lvl; p_dmode = dm;
    f = frame_cnt;
    wait (frame_cnt == f + 1);
    @(posedge clk);
    pic_err = 0; brd_err = 0; main_err = 0; rd_cnt = 0; pic_exp = 0; max_ya = 0;
    wait (frame_cnt == f + 2);
    @(posedge clk);
    nl = size ? LS : LL;
    check({tag, " R5 R6 picture pixel mismatches"}, pic_err, 0);
    check({tag, " R7 border pixel mismatches"}, brd_err, 0);
    check({tag, " R2 R3 R8 main pixel mismatches"}, main_err, 0);
    if (pip && dm == 0) begin
      check({tag, " R4 reads per field"}, rd_cnt, SW * nl);
      check({tag, " R6 last luma address"}, max_ya, SW * nl - 1);
    end else if (pip && dm == 2) begin
      check({tag, " R2 reads follow pin"}, rd_cnt, pic_exp);
    end else begin
      check({tag, " R2 no reads"}, rd_cnt, 0);
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R1 outputs in reset", int'({out_y, out_u, out_v}), 0);
    check("R1 rd_en in reset", int'(rd_en), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after release", int'({out_y, out_u, out_v}), 0);
    go = 1'b1;
  endtask

  task automatic t_passthrough();  run_field("pip off",        1'b0, 1'b0, 2'd0, 1'b1, 8'hEB, 0); endtask
  task automatic t_pin_low();      run_field("pin low",        1'b1, 1'b0, 2'd0, 1'b1, 8'hEB, 1); endtask
  task automatic t_top_left();     run_field("top left large", 1'b1, 1'b0, 2'd0, 1'b1, 8'hEB, 0); endtask
  task automatic t_bottom_right(); run_field("bot right small",1'b1, 1'b1, 2'd3, 1'b0, 8'hEB, 0); endtask
  task automatic t_top_right();    run_field("top right small",1'b1, 1'b1, 2'd1, 1'b1, 8'h10, 0); endtask
  task automatic t_bottom_left();  run_field("bot left large", 1'b1, 1'b0, 2'd2, 1'b1, 8'h55, 0); endtask
  task automatic t_pin_toggle();   run_field("pin toggling",   1'b1, 1'b0, 2'd0, 1'b1, 8'hC0, 2); endtask

  initial begin
    t_reset();
    t_passthrough();
    t_pin_low();
    t_top_left();
    t_bottom_right();
    t_top_right();
    t_bottom_left();
    t_pin_toggle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule